// File: doc/BRIEF.md
# 16-bit Timer/Counter with Capture and Reload

This block is a 16-bit up/down counter paired with a 16-bit capture/reload register. It advances either once per machine cycle (timer function) or once per falling edge seen on an external count pin (counter function). A machine cycle is `MC_DIV` clocks long, 12 by default.

A second external pin acts as a trigger. Depending on the mode, a falling edge on it either snapshots the running count or forces a reload. Four modes are available:
- capture with free wrap-around;
- reload on overflow while counting up;
- reload at a floor while counting down;
- a baud-clock mode that reloads on overflow and emits a one-clock tick in place of raising the overflow flag.

Software reaches the block through a byte-wide register port with five locations:
- the control byte;
- the two counter halves;
- the two capture/reload halves.

Top module: `tmr16_cap_reload`

## Requirements
- R1: After reset, every register location reads 0 and `baud_tick` is low.
- R2: Register addresses:
  - 0 is the control byte;
  - 1 and 2 are the counter low and high bytes;
  - 3 and 4 are the capture/reload low and high bytes;
  - any other address reads 0.

  Control bit fields:
  - bit 7 is the overflow flag;
  - bit 6 is the trigger flag;
  - bit 5 is the trigger enable;
  - bit 4 is run;
  - bit 3 is the count source (1 = external pin);
  - bits 2:1 are the mode (00 capture, 01 up-reload, 10 down-reload, 11 baud);
  - bit 0 always reads 0.

  A write is visible on the following clock and takes priority over any hardware update to that register in the same clock. Flags are cleared by writing 0 to them.
- R3: Machine-cycle boundaries fall on every `MC_DIV`-th rising clock edge counted from reset release. In timer function the counter changes by one step at each boundary while run is set. With run clear, the counter does not move.
- R4: In counter function the count pin is sampled only at boundaries. A high sample followed by a low sample at the next boundary registers one event, and the counter steps at the boundary after that. A low pulse that starts and ends between two boundaries is not counted.
- R5: In capture mode the counter counts up and wraps from FFFFh to 0000h, setting the overflow flag.
- R6: In capture mode, a trigger falling edge (high sample then low sample at boundaries, with trigger enable and run set) copies the counter value held before that boundary's step into the capture/reload pair and sets the trigger flag. With trigger enable clear, the pair and the flag are unchanged.
- R7: In up-reload mode, a step from FFFFh loads the reload pair and sets the overflow flag. An enabled trigger falling edge also loads the reload pair, overriding the step, and sets the trigger flag.
- R8: In down-reload mode the counter counts down. A step taken while the counter equals the reload pair loads FFFFh and sets the overflow flag.
- R9: In baud mode the counter counts up and reloads from the pair on a step from FFFFh. That event drives `baud_tick` high for exactly one clock and leaves the overflow flag unchanged.
- R10: When a capture trigger and a wrap from FFFFh fall on the same boundary, the capture pair receives FFFFh, the counter becomes 0000h, and both flags are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ext_cnt | input | 1 | External count pin |
| ext_trig | input | 1 | External trigger pin |
| baud_tick | output | 1 | One-clock pulse at each baud-mode overflow |

## Verification
The two functions that can land on one boundary are a capture and a counter wrap. Both are decided by the same clock edge, and one writes the capture pair while the other rewrites the counter and its flag.

The bench loads FFFFh into a running capture-mode counter and drops the trigger a couple of clocks before the next boundary. It then judges the outcome from the register port: the pair must hold the pre-step value FFFFh, the counter must read 0000h, and both the overflow and trigger flags must be set. The same timing discipline, with the trigger lowered late in a machine cycle, is used to compare a captured value against a counter value read just before the boundary.

// File: rtl/tmr16_cap_reload.sv
module tmr16_cap_reload #(
  parameter int MC_DIV = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       ext_cnt,
  input  logic       ext_trig,
  output logic       baud_tick
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DIVW = (MC_DIV > 1) ? $clog2(MC_DIV) : 1;
  localparam logic [DIVW-1:0] DIV_LAST = DIVW'(MC_DIV - 1);
  localparam logic [1:0] M_CAP = 2'b00, M_UP = 2'b01, M_DN = 2'b10, M_BAUD = 2'b11;
  localparam logic [2:0] A_CTRL = 3'd0, A_CNTL = 3'd1, A_CNTH = 3'd2,
                         A_RLDL = 3'd3, A_RLDH = 3'd4;

  logic [DIVW-1:0] div_q;
  logic [15:0]     cnt_q, rld_q, cnt_d, rld_d;
  logic            ovf_q, tflg_q, ten_q, run_q, csel_q;
  logic [1:0]      mode_q;
  logic            csmp_q, cpend_q, tsmp_q, tick_q;
  logic            ovf_set, tflg_set, tick_d;
  logic [7:0]      ctrl_q;

  wire mc_stb  = (div_q == DIV_LAST);
  wire inc     = run_q & mc_stb & (csel_q ? cpend_q : 1'b1);
  wire tfall   = run_q & mc_stb & ten_q & tsmp_q & ~ext_trig;
  wire cnt_max = &cnt_q;
  wire wr_ctrl = reg_we & (reg_addr == A_CTRL);
  wire wr_cntl = reg_we & (reg_addr == A_CNTL);
  wire wr_cnth = reg_we & (reg_addr == A_CNTH);
  wire wr_rldl = reg_we & (reg_addr == A_RLDL);
  wire wr_rldh = reg_we & (reg_addr == A_RLDH);

  assign ctrl_q    = {ovf_q, tflg_q, ten_q, run_q, csel_q, mode_q, 1'b0};
  assign baud_tick = tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= mc_stb ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csmp_q  <= 1'b0;
      cpend_q <= 1'b0;
      tsmp_q  <= 1'b0;
    end else if (mc_stb) begin
      csmp_q  <= ext_cnt;
      cpend_q <= csmp_q & ~ext_cnt;
      tsmp_q  <= ext_trig;
    end
  end

  always_comb begin
    cnt_d    = cnt_q;
    rld_d    = rld_q;
    ovf_set  = 1'b0;
    tflg_set = 1'b0;
    tick_d   = 1'b0;
    unique case (mode_q)
      M_CAP: begin
        if (tfall) begin
          rld_d    = cnt_q;
          tflg_set = 1'b1;
        end
        if (inc) begin
          cnt_d   = cnt_q + 16'd1;
          ovf_set = cnt_max;
        end
      end
      M_UP: begin
        if (tfall) begin
          cnt_d    = rld_q;
          tflg_set = 1'b1;
          ovf_set  = inc & cnt_max;
        end else if (inc) begin
          cnt_d   = cnt_max ? rld_q : cnt_q + 16'd1;
          ovf_set = cnt_max;
        end
      end
      M_DN: begin
        if (inc) begin
          cnt_d   = (cnt_q == rld_q) ? 16'hFFFF : cnt_q - 16'd1;
          ovf_set = (cnt_q == rld_q);
        end
      end
      M_BAUD: begin
        if (inc) begin
          cnt_d  = cnt_max ? rld_q : cnt_q + 16'd1;
          tick_d = cnt_max;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= tick_d;
      if (wr_cntl)      cnt_q <= {cnt_q[15:8], reg_wdata};
      else if (wr_cnth) cnt_q <= {reg_wdata, cnt_q[7:0]};
      else              cnt_q <= cnt_d;
      if (wr_rldl)      rld_q <= {rld_q[15:8], reg_wdata};
      else if (wr_rldh) rld_q <= {reg_wdata, rld_q[7:0]};
      else              rld_q <= rld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ovf_q, tflg_q, ten_q, run_q, csel_q, mode_q} <= '0;
    end else if (wr_ctrl) begin
      {ovf_q, tflg_q, ten_q, run_q, csel_q, mode_q} <= reg_wdata[7:1];
    end else begin
      ovf_q  <= ovf_q | ovf_set;
      tflg_q <= tflg_q | tflg_set;
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_CNTL:  reg_rdata = cnt_q[7:0];
      A_CNTH:  reg_rdata = cnt_q[15:8];
      A_RLDL:  reg_rdata = rld_q[7:0];
      A_RLDH:  reg_rdata = rld_q[15:8];
      default: reg_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/tmr16_cap_reload_chk.sv
module tmr16_cap_reload_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic        mc_stb,
  input logic        baud_tick,
  input logic [15:0] cnt_q,
  input logic [15:0] rld_q,
  input logic [6:0]  ctl
);
  timeunit 1ns;
  timeprecision 1ps;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $rose(rst_n) |-> (cnt_q == 16'h0 && rld_q == 16'h0 && ctl == 7'h0)); // R1

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl[3] && !reg_we) |=> $stable(cnt_q)); // R3

  AST_CAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[1:0] == 2'b00 && !reg_we) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 16'd1)); // R5

  AST_UP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_stb && ctl[3:0] == 4'b1001 && (&cnt_q) && !reg_we) |=> (cnt_q == $past(rld_q))); // R7

  AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_stb && ctl[3:0] == 4'b1010 && cnt_q == rld_q && !reg_we) |=> (cnt_q == 16'hFFFF)); // R8

  AST_TICK_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick); // R9

  AST_TICK_IN_BAUD: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> ($past(ctl[1:0]) == 2'b11)); // R9

  AST_BAUD_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_stb && ctl[1:0] == 2'b11 && !ctl[6] && !reg_we) |=> !ctl[6]); // R9

endmodule

bind tmr16_cap_reload tmr16_cap_reload_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .mc_stb    (mc_stb),
  .baud_tick (baud_tick),
  .cnt_q     (cnt_q),
  .rld_q     (rld_q),
  .ctl       (ctrl_q[7:1])
);

// File: tb/tmr16_cap_reload_tb_top.sv
module tmr16_cap_reload_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int MC = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ext_cnt = 1'b0;
  logic       ext_trig = 1'b0;
  logic       baud_tick;

  int n_chk = 0;
  int n_fail = 0;
  int ph = 0;
  int tick_cnt = 0;
  logic tick_clr = 1'b0;
  logic done = 1'b0;

  tmr16_cap_reload #(.MC_DIV(MC)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_cnt(ext_cnt),
    .ext_trig(ext_trig), .baud_tick(baud_tick)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) ph <= 0;
    else        ph <= (ph == MC - 1) ? 0 : ph + 1;
  end

  always @(posedge clk) begin
    if (tick_clr)       tick_cnt <= 0;
    else if (baud_tick) tick_cnt <= tick_cnt + 1;
  end

  typedef struct packed {
    logic [1:0]  mode;
    logic        run;
    logic [15:0] start;
    logic [15:0] rld;
    logic [7:0]  n;
    logic [15:0] exp;
    logic        ovf;
    logic [3:0]  ticks;
  } vec_t;

  localparam vec_t VEC [7] = '{
    {2'd0, 1'b1, 16'h0010, 16'h0000, 8'd5, 16'h0015, 1'b0, 4'd0},
    {2'd0, 1'b1, 16'hFFFE, 16'h0000, 8'd3, 16'h0001, 1'b1, 4'd0},
    {2'd1, 1'b1, 16'hFFFD, 16'h1234, 8'd4, 16'h1235, 1'b1, 4'd0},
    {2'd2, 1'b1, 16'h0105, 16'h0100, 8'd3, 16'h0102, 1'b0, 4'd0},
    {2'd2, 1'b1, 16'h0102, 16'h0100, 8'd4, 16'hFFFE, 1'b1, 4'd0},
    {2'd3, 1'b1, 16'hFFFE, 16'hFFFC, 8'd7, 16'hFFFD, 1'b0, 4'd2},
    {2'd0, 1'b0, 16'h4321, 16'h0000, 8'd4, 16'h4321, 1'b0, 4'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a + 3'd1, hi);
    d = {hi, lo};
  endtask

  task automatic next_ph(input int v);
    @(negedge clk);
    while (ph != v) @(negedge clk);
  endtask

  task automatic put16(input logic [2:0] a, input logic [15:0] d);
    wr(a, d[7:0]);
    wr(a + 3'd1, d[15:8]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w, v0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 baud_tick", {31'd0, baud_tick}, 32'd0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), b);
      chk("R1 register after reset", {24'd0, b}, 32'd0);
    end

    // R2: map, readback, unmapped address
    wr(0, 8'hEF);
    rd(0, b); chk("R2 control readback bit0 zero", {24'd0, b}, 32'h0000_00EE);
    wr(0, 8'h00);
    rd(0, b); chk("R2 flags cleared by write", {24'd0, b}, 32'd0);
    put16(1, 16'h1234);
    put16(3, 16'h5678);
    rd16(1, w); chk("R2 counter readback", {16'd0, w}, 32'h1234);
    rd16(3, w); chk("R2 reload readback", {16'd0, w}, 32'h5678);
    rd(5, b); chk("R2 unmapped address", {24'd0, b}, 32'd0);

    // Vector table: R3 R5 R7 R8 R9 in timer function
    for (int i = 0; i < 7; i++) begin
      vec_t vv;
      vv = VEC[i];
      wr(0, 8'h00);
      put16(1, vv.start);
      put16(3, vv.rld);
      tick_clr = 1'b1;
      @(negedge clk);
      tick_clr = 1'b0;
      while (ph != 0) @(negedge clk);
      wr(0, {3'b000, vv.run, 1'b0, vv.mode, 1'b0});
      repeat (MC * int'(vv.n) - 1) @(negedge clk);
      rd(0, b);
      rd16(1, w);
      chk($sformatf("R3/R5/R7/R8/R9 vector %0d count", i), {16'd0, w}, {16'd0, vv.exp});
      chk($sformatf("R5 R7 R8 R9 vector %0d overflow flag", i), {31'd0, b[7]}, {31'd0, vv.ovf});
      chk($sformatf("R9 vector %0d baud ticks", i), tick_cnt, {28'd0, vv.ticks});
    end

    // R4: counter function latency, max rate, short pulse
    wr(0, 8'h00);
    ext_cnt = 1'b1;
    put16(1, 16'h0000);
    wr(0, 8'h18);
    next_ph(0);
    next_ph(0);
    next_ph(5);
    ext_cnt = 1'b0;
    next_ph(0);
    rd(1, b); chk("R4 no step at detecting boundary", {24'd0, b}, 32'd0);
    next_ph(0);
    rd(1, b); chk("R4 step one boundary later", {24'd0, b}, 32'd1);
    for (int k = 0; k < 10; k++) begin
      next_ph(5); ext_cnt = 1'b1;
      next_ph(5); ext_cnt = 1'b0;
    end
    next_ph(0);
    next_ph(0);
    rd(1, b); chk("R4 one event per two machine cycles", {24'd0, b}, 32'd11);
    next_ph(2); ext_cnt = 1'b1;
    next_ph(6); ext_cnt = 1'b0;
    next_ph(0);
    next_ph(0);
    rd(1, b); chk("R4 pulse between boundaries ignored", {24'd0, b}, 32'd11);

    // R6: capture on trigger
    wr(0, 8'h00);
    ext_trig = 1'b1;
    put16(1, 16'h0100);
    wr(0, 8'h30);
    next_ph(0);
    next_ph(0);
    next_ph(8);
    rd16(1, v0);
    ext_trig = 1'b0;
    next_ph(0);
    rd16(3, w); chk("R6 captured pre-step value", {16'd0, w}, {16'd0, v0});
    rd(0, b);   chk("R6 trigger flag set", {24'd0, b}, 32'h70);
    rd16(1, w); chk("R6 counter still steps", {16'd0, w}, {16'd0, v0 + 16'd1});

    // R6: trigger disabled
    wr(0, 8'h00);
    ext_trig = 1'b1;
    put16(3, 16'hAAAA);
    wr(0, 8'h10);
    next_ph(0);
    next_ph(0);
    next_ph(5);
    ext_trig = 1'b0;
    next_ph(0);
    rd16(3, w); chk("R6 disabled trigger leaves pair", {16'd0, w}, 32'hAAAA);
    rd(0, b);   chk("R6 disabled trigger leaves flag", {24'd0, b}, 32'h10);

    // R7: trigger reload in up mode
    wr(0, 8'h00);
    ext_trig = 1'b1;
    put16(3, 16'h5000);
    put16(1, 16'h0010);
    wr(0, 8'h32);
    next_ph(0);
    next_ph(0);
    next_ph(5);
    ext_trig = 1'b0;
    next_ph(0);
    rd16(1, w); chk("R7 trigger reload", {16'd0, w}, 32'h5000);
    rd(0, b);   chk("R7 trigger flag", {24'd0, b}, 32'h72);

    // R10: capture and wrap on the same boundary
    wr(0, 8'h00);
    ext_trig = 1'b1;
    next_ph(0);
    put16(1, 16'hFFFF);
    wr(0, 8'h30);
    next_ph(9);
    ext_trig = 1'b0;
    next_ph(0);
    rd16(3, w); chk("R10 capture holds FFFF", {16'd0, w}, 32'hFFFF);
    rd16(1, w); chk("R10 counter wrapped", {16'd0, w}, 32'h0000);
    rd(0, b);   chk("R10 both flags", {24'd0, b}, 32'hF0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule